// File: doc/BRIEF.md
# Debug Breakpoint Trigger Unit

This block is a hardware breakpoint comparator for a 32-bit processor. It watches the bus address and bus data on cycles when the bus is valid, and the program counter on cycles when the fetch address is valid. It decides when a debug trigger fires. A register write port loads nine 32-bit comparison registers and one control register. The nine comparison registers are an address value and its mask, a data value and its mask, four program-counter values, and one mask that all four program-counter values share.

The control register picks which conditions make up the trigger level. It also picks the conditions that make up an optional arming level, selects one-level or two-level operation, and selects the action. In two-level mode the arming level has to hit on an earlier cycle than the trigger level. When the trigger fires, the block pulses a halt request or a debug-interrupt request for one cycle. A separate combinational flag reports that the 4-bit processor status input shows the halted code.

Top module: `bkpt_trigger_unit`

## Requirements
- R1: After synchronous reset, every comparison register and the control register are zero, both request outputs are low, and no trigger fires until the control register enables a condition.
- R2: The address condition holds when the bus is valid and `((bus_addr ^ addr_value) & ~addr_mask) == 0`. A mask bit of 1 removes that bit from the comparison.
- R3: The data condition holds when the bus is valid and `((bus_data ^ data_value) & ~data_mask) == 0`, using its own mask.
- R4: The PC condition holds when the PC strobe is high and any of the four PC values matches `pc` under the single shared PC mask.
- R5: No condition is true on a cycle where its strobe is low. The address and data conditions use `bus_valid`; the PC condition uses `pc_valid`.
- R6: A level hits when at least one of its enable bits is set and every enabled condition holds in the same cycle. Trigger enables are control bits [2:0] and arming enables are control bits [6:4]; within each group, bit 0 is address, bit 1 is data and bit 2 is PC. In one-level mode (control bit 8 = 0), a trigger-level hit fires.
- R7: In two-level mode (control bit 8 = 1), an arming-level hit sets a sticky armed flag from the next cycle on. A trigger-level hit fires only while the flag is already set, and firing does not clear the flag.
- R8: A high `arm_clear` clears the armed flag. It wins over an arming hit in the same cycle.
- R9: A firing drives exactly one of `halt_req` (control bit 9 = 0) or `dbg_irq_req` (control bit 9 = 1) high for one cycle, in the cycle after the clock edge that sampled the triggering inputs.
- R10: `cpu_halted` is high exactly when `cpu_status` equals 4'b1111.
- R11: Register offsets on `cfg_addr` are: 0 address value, 1 address mask, 2 data value, 3 data mask, 4 to 7 PC values 0 to 3, 8 PC mask, 9 control. A write takes effect for comparisons from the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | Bus address and data are valid this cycle |
| bus_addr | input | 32 | Observed bus address |
| bus_data | input | 32 | Observed bus data |
| pc_valid | input | 1 | Program counter is valid this cycle |
| pc | input | 32 | Observed program counter |
| arm_clear | input | 1 | Clears the two-level armed flag |
| cpu_status | input | 4 | Processor status code |
| halt_req | output | 1 | One-cycle halt request |
| dbg_irq_req | output | 1 | One-cycle debug-interrupt request |
| cpu_halted | output | 1 | Status equals the halted code |

## Verification
The bench drives every stimulus just after a falling edge. A request caused by that stimulus appears after the next rising edge, so the bench compares both request outputs at the following falling edge, exactly one cycle later. A register write sits on the port for one cycle and counts for comparisons only from the cycle after it. The armed flag therefore affects only a trigger hit presented at least one cycle after the arming hit, and the bench model updates its own armed flag only after it has predicted the current cycle. `cpu_halted` is combinational and is checked a short delay after the status changes, in the same cycle.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

    localparam int WORD_W   = 32;
    localparam int PC_SLOTS = 4;

    // register offsets
    localparam int OFS_ADDR_VAL = 0;
    localparam int OFS_ADDR_MSK = 1;
    localparam int OFS_DATA_VAL = 2;
    localparam int OFS_DATA_MSK = 3;
    localparam int OFS_PC_BASE  = 4;

    // condition index inside an enable group
    localparam int C_ADDR = 0;
    localparam int C_DATA = 1;
    localparam int C_PC   = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [2:0]        cond_vec_t;

    typedef struct packed {
        logic [21:0] spare_hi;
        logic        act_irq;    // bit 9
        logic        two_level;  // bit 8
        logic        spare7;
        cond_vec_t   arm_en;     // bits 6:4
        logic        spare3;
        cond_vec_t   trig_en;    // bits 2:0
    } trig_ctrl_t;

    function automatic logic masked_eq(word_t obs, word_t ref_v, word_t msk);
        return ((obs ^ ref_v) & ~msk) == '0;
    endfunction

    function automatic logic level_hit(cond_vec_t en, cond_vec_t cond);
        return (|en) && ((cond & en) == en);
    endfunction

endpackage

// File: rtl/bkpt_regfile.sv
module bkpt_regfile
    import dbg_trig_pkg::*;
#(
    parameter int NUM_PC = PC_SLOTS,
    parameter int AW     = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [AW-1:0]                 addr,
    input  word_t                         wdata,
    output word_t                         addr_val,
    output word_t                         addr_msk,
    output word_t                         data_val,
    output word_t                         data_msk,
    output logic [NUM_PC-1:0][WORD_W-1:0] pc_val,
    output word_t                         pc_msk,
    output trig_ctrl_t                    ctrl
);
    localparam int OFS_PC_MSK = OFS_PC_BASE + NUM_PC;
    localparam int OFS_CTRL   = OFS_PC_MSK + 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_val <= '0;
            addr_msk <= '0;
            data_val <= '0;
            data_msk <= '0;
            pc_msk   <= '0;
            ctrl     <= '0;
        end else if (we) begin
            if (addr == AW'(OFS_ADDR_VAL)) addr_val <= wdata;
            if (addr == AW'(OFS_ADDR_MSK)) addr_msk <= wdata;
            if (addr == AW'(OFS_DATA_VAL)) data_val <= wdata;
            if (addr == AW'(OFS_DATA_MSK)) data_msk <= wdata;
            if (addr == AW'(OFS_PC_MSK))   pc_msk   <= wdata;
            if (addr == AW'(OFS_CTRL))     ctrl     <= trig_ctrl_t'(wdata);
        end
    end

    for (genvar i = 0; i < NUM_PC; i++) begin : g_pc
        always_ff @(posedge clk) begin
            if (rst)
                pc_val[i] <= '0;
            else if (we && addr == AW'(OFS_PC_BASE + i))
                pc_val[i] <= wdata;
        end
    end

endmodule

// File: rtl/bkpt_mask_cmp.sv
module bkpt_mask_cmp
    import dbg_trig_pkg::*;
#(
    parameter int NUM_REF = 1
) (
    input  logic                           valid,
    input  word_t                          obs,
    input  logic [NUM_REF-1:0][WORD_W-1:0] ref_vals,
    input  word_t                          msk,
    output logic                           hit
);
    logic [NUM_REF-1:0] each_eq;

    for (genvar i = 0; i < NUM_REF; i++) begin : g_ref
        assign each_eq[i] = masked_eq(obs, ref_vals[i], msk);
    end

    assign hit = valid && (|each_eq);

endmodule

// File: rtl/bkpt_sequencer.sv
module bkpt_sequencer
    import dbg_trig_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig_hit,
    input  logic arm_hit,
    input  logic two_level,
    input  logic act_irq,
    input  logic arm_clr,
    output logic halt_req,
    output logic irq_req
);
    logic armed_q;
    logic fire;

    assign fire = trig_hit && (!two_level || armed_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            halt_req <= 1'b0;
            irq_req  <= 1'b0;
        end else begin
            if (arm_clr)
                armed_q <= 1'b0;
            else if (two_level && arm_hit)
                armed_q <= 1'b1;
            halt_req <= fire && !act_irq;
            irq_req  <= fire && act_irq;
        end
    end

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        !(halt_req && irq_req));  // R9

    AST_CLEAR_DISARMS: assert property (@(posedge clk) disable iff (rst)
        arm_clr |=> !armed_q);  // R8

    AST_SECOND_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        ((halt_req || irq_req) && $past(two_level)) |-> $past(armed_q));  // R7

endmodule

// File: rtl/bkpt_trigger_unit.sv
module bkpt_trigger_unit
    import dbg_trig_pkg::*;
#(
    parameter int NUM_PC = PC_SLOTS,
    parameter int CFG_AW = $clog2(NUM_PC + 6)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              bus_valid,
    input  logic [31:0]       bus_addr,
    input  logic [31:0]       bus_data,
    input  logic              pc_valid,
    input  logic [31:0]       pc,
    input  logic              arm_clear,
    input  logic [3:0]        cpu_status,
    output logic              halt_req,
    output logic              dbg_irq_req,
    output logic              cpu_halted
);
    word_t                         addr_val, addr_msk, data_val, data_msk, pc_msk;
    logic [NUM_PC-1:0][WORD_W-1:0] pc_val;
    trig_ctrl_t                    ctrl;
    cond_vec_t                     cond;
    logic                          trig_hit, arm_hit;

    bkpt_regfile #(.NUM_PC(NUM_PC), .AW(CFG_AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .addr_val (addr_val),
        .addr_msk (addr_msk),
        .data_val (data_val),
        .data_msk (data_msk),
        .pc_val   (pc_val),
        .pc_msk   (pc_msk),
        .ctrl     (ctrl)
    );

    bkpt_mask_cmp #(.NUM_REF(1)) u_cmp_addr (
        .valid    (bus_valid),
        .obs      (bus_addr),
        .ref_vals (addr_val),
        .msk      (addr_msk),
        .hit      (cond[C_ADDR])
    );

    bkpt_mask_cmp #(.NUM_REF(1)) u_cmp_data (
        .valid    (bus_valid),
        .obs      (bus_data),
        .ref_vals (data_val),
        .msk      (data_msk),
        .hit      (cond[C_DATA])
    );

    bkpt_mask_cmp #(.NUM_REF(NUM_PC)) u_cmp_pc (
        .valid    (pc_valid),
        .obs      (pc),
        .ref_vals (pc_val),
        .msk      (pc_msk),
        .hit      (cond[C_PC])
    );

    assign trig_hit = level_hit(ctrl.trig_en, cond);
    assign arm_hit  = level_hit(ctrl.arm_en, cond);

    bkpt_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .trig_hit  (trig_hit),
        .arm_hit   (arm_hit),
        .two_level (ctrl.two_level),
        .act_irq   (ctrl.act_irq),
        .arm_clr   (arm_clear),
        .halt_req  (halt_req),
        .irq_req   (dbg_irq_req)
    );

    assign cpu_halted = &cpu_status;

    AST_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        (halt_req || dbg_irq_req) |-> $past(bus_valid || pc_valid));  // R5

    AST_RESET_QUIET: assert property (@(posedge clk)
        $rose(rst) |=> !halt_req && !dbg_irq_req);  // R1

endmodule

// File: tb/bkpt_trigger_unit_bench.sv
module bkpt_trigger_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        bus_valid;
    logic [31:0] bus_addr, bus_data;
    logic        pc_valid;
    logic [31:0] pc;
    logic        arm_clear;
    logic [3:0]  cpu_status;
    logic        halt_req, dbg_irq_req, cpu_halted;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // shadow model
    logic [31:0] s_av, s_am, s_dv, s_dm, s_pm, s_ctrl;
    logic [31:0] s_pc [4];
    bit          m_armed;

    always #10 clk = ~clk;

    bkpt_trigger_unit u_bkpt_trigger_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_data(bus_data), .pc_valid(pc_valid), .pc(pc),
        .arm_clear(arm_clear), .cpu_status(cpu_status),
        .halt_req(halt_req), .dbg_irq_req(dbg_irq_req), .cpu_halted(cpu_halted)
    );

    function automatic logic [31:0] mk_ctrl(bit irq, bit two, logic [2:0] arm, logic [2:0] trig);
        return {22'b0, irq, two, 1'b0, arm, 1'b0, trig};
    endfunction

    function automatic bit meq(logic [31:0] o, logic [31:0] r, logic [31:0] m);
        return ((o ^ r) & ~m) == 0;
    endfunction

    function automatic bit lvl(logic [2:0] en, logic [2:0] c);
        return (en != 0) && ((c & en) == en);
    endfunction

    task automatic check(bit got, bit exp, string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, got, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
        case (a)
            0: s_av = d;  1: s_am = d;  2: s_dv = d;  3: s_dm = d;
            4, 5, 6, 7: s_pc[a-4] = d;
            8: s_pm = d;  9: s_ctrl = d;
            default: ;
        endcase
    endtask

    task automatic cyc(bit bv, logic [31:0] ba, logic [31:0] bd, bit pv, logic [31:0] p,
                       bit clr, bit eh, bit ei, string tag);
        bus_valid = bv; bus_addr = ba; bus_data = bd;
        pc_valid = pv; pc = p; arm_clear = clr;
        @(negedge clk);
        check(halt_req, eh, {tag, " halt"});
        check(dbg_irq_req, ei, {tag, " irq"});
        bus_valid = 0; pc_valid = 0; arm_clear = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        bus_valid = 0; bus_addr = 0; bus_data = 0; pc_valid = 0; pc = 0;
        arm_clear = 0; cpu_status = 0;
        s_av = 0; s_am = 0; s_dv = 0; s_dm = 0; s_pm = 0; s_ctrl = 0;
        for (int i = 0; i < 4; i++) s_pc[i] = 0;
        m_armed = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check(halt_req, 0, "R1 reset halt");
        check(dbg_irq_req, 0, "R1 reset irq");
        // zero registers would match zeros, but nothing is enabled
        cyc(1, 0, 0, 1, 0, 0, 0, 0, "R1 disabled");

        // R2 address with mask, R11 offsets 0,1,9
        wr(0, 32'h1000_0040); wr(1, 32'h0000_000F); wr(9, mk_ctrl(0, 0, 3'b000, 3'b001));
        cyc(1, 32'h1000_004A, 0, 0, 0, 0, 1, 0, "R2 masked match");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R9 pulse ends");
        cyc(1, 32'h1000_005A, 0, 0, 0, 0, 0, 0, "R2 unmasked bit differs");
        cyc(0, 32'h1000_0040, 0, 0, 0, 0, 0, 0, "R5 bus strobe low");

        // R3 data, irq action
        wr(2, 32'hCAFE_0000); wr(3, 32'h0000_FFFF); wr(9, mk_ctrl(1, 0, 3'b000, 3'b010));
        cyc(1, 0, 32'hCAFE_1234, 0, 0, 0, 0, 1, "R3 R9 data irq");
        cyc(1, 0, 32'hCAFF_1234, 0, 0, 0, 0, 0, "R3 data differs");

        // R4 four PC values, shared mask
        wr(4, 32'h100); wr(5, 32'h200); wr(6, 32'h300); wr(7, 32'h400); wr(8, 32'h3);
        wr(9, mk_ctrl(0, 0, 3'b000, 3'b100));
        cyc(0, 0, 0, 1, 32'h303, 0, 1, 0, "R4 pc slot2");
        cyc(0, 0, 0, 1, 32'h402, 0, 1, 0, "R4 pc slot3");
        cyc(0, 0, 0, 1, 32'h404, 0, 0, 0, "R4 pc outside mask");
        cyc(0, 0, 0, 0, 32'h100, 0, 0, 0, "R5 pc strobe low");

        // R6 combined level
        wr(9, mk_ctrl(0, 0, 3'b000, 3'b011));
        cyc(1, 32'h1000_0040, 32'h0000_0000, 0, 0, 0, 0, 0, "R6 data missing");
        cyc(1, 32'h1000_0041, 32'hCAFE_0001, 0, 0, 0, 1, 0, "R6 both hold");

        // R7 two-level: arm on PC, trigger on address
        wr(9, mk_ctrl(1, 1, 3'b100, 3'b001));
        cyc(1, 32'h1000_0040, 0, 0, 0, 0, 0, 0, "R7 not armed");
        cyc(1, 32'h1000_0040, 0, 1, 32'h100, 0, 0, 0, "R7 same cycle arm");
        cyc(1, 32'h1000_0040, 0, 0, 0, 0, 0, 1, "R7 armed fires");
        cyc(1, 32'h1000_0040, 0, 0, 0, 0, 0, 1, "R7 sticky");
        // R8 clear wins over arm hit
        cyc(0, 0, 0, 1, 32'h200, 1, 0, 0, "R8 clear cycle");
        cyc(1, 32'h1000_0040, 0, 0, 0, 0, 0, 0, "R8 disarmed");

        // R10
        cpu_status = 4'hF; #1 check(cpu_halted, 1, "R10 halted");
        cpu_status = 4'hE; #1 check(cpu_halted, 0, "R10 e");
        cpu_status = 4'h7; #1 check(cpu_halted, 0, "R10 7");
        @(negedge clk);

        // random phase
        cyc(0, 0, 0, 0, 0, 1, 0, 0, "R8 reset model");
        m_armed = 0;
        for (int k = 0; k < 40; k++) begin
            wr(0, $urandom); wr(1, $urandom & $urandom);
            wr(2, $urandom); wr(3, $urandom & $urandom);
            for (int i = 0; i < 4; i++) wr(4 + i, $urandom);
            wr(8, $urandom & $urandom & $urandom);
            wr(9, mk_ctrl(1'($urandom), 1'($urandom), 3'($urandom), 3'($urandom)));
            for (int t = 0; t < 12; t++) begin
                bit bv, pv, clr, two, fire;
                logic [31:0] ba, bd, p;
                logic [2:0] c;
                bv = ($urandom % 4) != 0; pv = ($urandom % 4) != 0;
                clr = ($urandom % 10) == 0;
                ba = ($urandom % 3 != 0) ? (s_av ^ ($urandom & s_am)) : $urandom;
                bd = ($urandom % 3 != 0) ? (s_dv ^ ($urandom & s_dm)) : $urandom;
                p  = ($urandom % 3 != 0) ? (s_pc[$urandom % 4] ^ ($urandom & s_pm)) : $urandom;
                c[0] = bv && meq(ba, s_av, s_am);
                c[1] = bv && meq(bd, s_dv, s_dm);
                c[2] = pv && (meq(p, s_pc[0], s_pm) || meq(p, s_pc[1], s_pm) ||
                              meq(p, s_pc[2], s_pm) || meq(p, s_pc[3], s_pm));
                two  = s_ctrl[8];
                fire = lvl(s_ctrl[2:0], c) && (!two || m_armed);
                cyc(bv, ba, bd, pv, p, clr, fire && !s_ctrl[9], fire && s_ctrl[9],
                    "R6 R7 random");
                if (clr) m_armed = 0;
                else if (two && lvl(s_ctrl[6:4], c)) m_armed = 1;
            end
        end

        // R1 reset again clears everything
        wr(9, mk_ctrl(0, 0, 3'b000, 3'b001)); wr(1, 32'hFFFF_FFFF);
        rst = 1; @(negedge clk); rst = 0;
        cyc(1, 32'h1234_5678, 0, 0, 0, 0, 0, 0, "R1 reset clears control");

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule